// File: doc/BRIEF.md
# Grayscale LCD Column Line-Scan Controller

This block feeds the column outputs of a grayscale liquid-crystal column driver. It holds a full-frame bitmap with two bits (four gray levels) per pixel, keeps a display-line counter, and on every falling edge of the line clock it copies the row under that counter into an output latch. The latched row is then encoded into one 3-bit drive-level select per column. The encoding takes the AC polarity input into account, so the panel never sees a steady bias. A blanking input forces every column to the select-high level without touching the bitmap. A mirror strap reverses the column order for panels mounted the other way round.

A host fills the bitmap one byte (four pixels) at a time. A 2-bit device ID on the write port is compared with two strap pins, so up to four of these blocks can share one write bus. Writes whose ID does not match leave the memory unchanged. The line clock and frame-start inputs are sampled on the block clock, and all outputs are registered.

Top module: `lcd_col_scan`

## Requirements
- R1: After reset every column select is 3'b000 and the line counter is 0, so the first line-clock falling edge latches row 0.
- R2: A falling edge of `line_clk`, seen as a high sample followed by a low sample on `clk`, latches the row selected by the line counter and advances the counter by one. The new column selects appear on the second rising `clk` edge after `line_clk` is first sampled low.
- R3: After the last line (NUM_LINES-1, default 239) the counter wraps to 0.
- R4: While `frame_sync` is high the line counter is held at 0, and a line-clock falling edge in that time latches row 0.
- R5: Each column select encodes the gray level g of its pixel as {1'b0,g} when `ac_sel` is 0 and as {1'b1,~g} when `ac_sel` is 1. A change of `ac_sel` takes effect at the next rising `clk` edge.
- R6: While `blank_n` is low every column select is 3'b111 (select-high), from the next rising edge on. When `blank_n` returns high, the previously latched row is shown again with its contents unchanged.
- R7: Host writes with a matching ID are stored while `blank_n` is low, exactly as they are when it is high.
- R8: With `mirror` high, output i (select bits [3i+2:3i]) carries bitmap column NUM_COLS-1-i. With `mirror` low it carries column i. The change takes effect at the next rising edge.
- R9: A write strobe whose `wr_id` differs from the `dev_id` straps leaves the bitmap unchanged.
- R10: A write stores `wr_data[2k+1:2k]` as the pixel of column 4*`wr_grp`+k of row `wr_row`, for k = 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Frame start; holds the line counter at 0 while high |
| line_clk | input | 1 | Line clock; the row is latched on its falling edge |
| ac_sel | input | 1 | AC drive polarity select |
| blank_n | input | 1 | Low forces all columns to select-high |
| mirror | input | 1 | Strap that reverses the column order |
| dev_id | input | 2 | Strapped device ID |
| wr_en | input | 1 | Single-cycle host write strobe |
| wr_id | input | 2 | Target device ID of the write |
| wr_row | input | 8 | Bitmap row of the write |
| wr_grp | input | 6 | Four-pixel column group of the write |
| wr_data | input | 8 | Four 2-bit pixels |
| col_lvl | output | 480 | 3-bit level select per column, column output i at bits [3i+2:3i] |

## Verification
Line data reaches the outputs two rising edges after `line_clk` is first sampled low: one edge to detect the fall and latch the row, one edge to encode it. Polarity, blanking and mirror changes appear after a single edge. The driver pushes each expected vector only after the matching number of rising edges. The monitor compares it at the following falling edge, where the registered outputs are stable. The bench keeps its own line counter and its own per-row data generation, so counter wrap, frame restarts, ignored writes and writes made during blanking all show up as differences in the latched row.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

    typedef logic [1:0] gray_t;
    typedef logic [2:0] lvl_t;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pol_e;

    localparam lvl_t LVL_SEL_HIGH = 3'b111;
    localparam int   PIX_W        = 2;
    localparam int   LVL_W        = 3;
    localparam int   PIX_PER_GRP  = 4;

    function automatic lvl_t lvl_encode(gray_t g, pol_e pol, logic blank_n);
        if (!blank_n)
            return LVL_SEL_HIGH;
        else if (pol == POL_NEG)
            return {1'b1, ~g};
        else
            return {1'b0, g};
    endfunction

endpackage

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
    parameter  int NUM_LINES = 240,
    localparam int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic              line_clk,
    output logic              lat_stb,
    output logic [LINE_W-1:0] line
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(NUM_LINES - 1);

    logic lclk_q;

    assign lat_stb = lclk_q & ~line_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            lclk_q <= 1'b0;
            line   <= '0;
        end else begin
            lclk_q <= line_clk;
            if (frame_sync)
                line <= '0;
            else if (lat_stb)
                line <= (line == LAST) ? '0 : line + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_bitmap_ram.sv
module lcd_bitmap_ram
    import lcd_col_pkg::*;
#(
    parameter  int NUM_COLS  = 160,
    parameter  int NUM_LINES = 240,
    localparam int LINE_W    = $clog2(NUM_LINES),
    localparam int NUM_GRPS  = NUM_COLS / PIX_PER_GRP,
    localparam int GRP_W     = $clog2(NUM_GRPS),
    localparam int ROW_W     = NUM_COLS * PIX_W,
    localparam int BYTE_W    = PIX_PER_GRP * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        dev_id,
    input  logic              wr_en,
    input  logic [1:0]        wr_id,
    input  logic [LINE_W-1:0] wr_row,
    input  logic [GRP_W-1:0]  wr_grp,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              lat_stb,
    input  logic [LINE_W-1:0] rd_line,
    output logic              row_we,
    output logic [ROW_W-1:0]  row_q
);
    logic [ROW_W-1:0] mem [NUM_LINES];

    assign row_we = wr_en && (wr_id == dev_id)
                 && (int'(wr_row) < NUM_LINES) && (int'(wr_grp) < NUM_GRPS);

    always_ff @(posedge clk) begin
        if (row_we)
            mem[wr_row][int'(wr_grp) * BYTE_W +: BYTE_W] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            row_q <= '0;
        else if (lat_stb)
            row_q <= mem[rd_line];
    end
endmodule

// File: rtl/lcd_col_encoder.sv
module lcd_col_encoder
    import lcd_col_pkg::*;
#(
    parameter  int NUM_COLS = 160,
    localparam int ROW_W    = NUM_COLS * PIX_W,
    localparam int OUT_W    = NUM_COLS * LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] row_q,
    input  logic             ac_sel,
    input  logic             blank_n,
    input  logic             mirror,
    output logic [OUT_W-1:0] col_lvl
);
    pol_e pol;
    assign pol = ac_sel ? POL_NEG : POL_POS;

    for (genvar i = 0; i < NUM_COLS; i++) begin : g_col
        gray_t pix;
        assign pix = mirror ? row_q[PIX_W*(NUM_COLS-1-i) +: PIX_W]
                            : row_q[PIX_W*i +: PIX_W];
        always_ff @(posedge clk) begin
            if (rst)
                col_lvl[LVL_W*i +: LVL_W] <= '0;
            else
                col_lvl[LVL_W*i +: LVL_W] <= lvl_encode(pix, pol, blank_n);
        end
    end
endmodule

// File: rtl/lcd_col_scan.sv
module lcd_col_scan
    import lcd_col_pkg::*;
#(
    parameter  int NUM_COLS  = 160,
    parameter  int NUM_LINES = 240,
    localparam int LINE_W    = $clog2(NUM_LINES),
    localparam int GRP_W     = $clog2(NUM_COLS / PIX_PER_GRP),
    localparam int BYTE_W    = PIX_PER_GRP * PIX_W,
    localparam int ROW_W     = NUM_COLS * PIX_W,
    localparam int OUT_W     = NUM_COLS * LVL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic              line_clk,
    input  logic              ac_sel,
    input  logic              blank_n,
    input  logic              mirror,
    input  logic [1:0]        dev_id,
    input  logic              wr_en,
    input  logic [1:0]        wr_id,
    input  logic [LINE_W-1:0] wr_row,
    input  logic [GRP_W-1:0]  wr_grp,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [OUT_W-1:0]  col_lvl
);
    logic              lat_stb;
    logic [LINE_W-1:0] line;
    logic              row_we;
    logic [ROW_W-1:0]  row_q;

    lcd_line_ctr #(.NUM_LINES(NUM_LINES)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .line_clk   (line_clk),
        .lat_stb    (lat_stb),
        .line       (line)
    );

    lcd_bitmap_ram #(.NUM_COLS(NUM_COLS), .NUM_LINES(NUM_LINES)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .dev_id  (dev_id),
        .wr_en   (wr_en),
        .wr_id   (wr_id),
        .wr_row  (wr_row),
        .wr_grp  (wr_grp),
        .wr_data (wr_data),
        .lat_stb (lat_stb),
        .rd_line (line),
        .row_we  (row_we),
        .row_q   (row_q)
    );

    lcd_col_encoder #(.NUM_COLS(NUM_COLS)) u_enc (
        .clk     (clk),
        .rst     (rst),
        .row_q   (row_q),
        .ac_sel  (ac_sel),
        .blank_n (blank_n),
        .mirror  (mirror),
        .col_lvl (col_lvl)
    );
endmodule

// File: rtl/lcd_col_scan_chk.sv
module lcd_col_scan_chk #(
    parameter  int NUM_COLS  = 160,
    parameter  int NUM_LINES = 240,
    localparam int LINE_W    = $clog2(NUM_LINES),
    localparam int OUT_W     = NUM_COLS * 3
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_sync,
    input logic              blank_n,
    input logic              lat_stb,
    input logic [LINE_W-1:0] line,
    input logic              row_we,
    input logic              wr_en,
    input logic [1:0]        wr_id,
    input logic [1:0]        dev_id,
    input logic [OUT_W-1:0]  col_lvl
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(NUM_LINES - 1);

    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (lat_stb && !frame_sync && line != LAST) |=> line == $past(line) + 1'b1);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!lat_stb && !frame_sync) |=> $stable(line));

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (lat_stb && !frame_sync && line == LAST) |=> line == '0);

    a_r4_frame_hold: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> line == '0);

    a_r6_blank_level: assert property (@(posedge clk) disable iff (rst)
        !blank_n |=> col_lvl == {NUM_COLS{3'b111}});

    a_r9_id_gate: assert property (@(posedge clk) disable iff (rst)
        row_we |-> (wr_en && wr_id == dev_id));
endmodule

bind lcd_col_scan lcd_col_scan_chk #(.NUM_COLS(NUM_COLS), .NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .blank_n    (blank_n),
    .lat_stb    (lat_stb),
    .line       (line),
    .row_we     (row_we),
    .wr_en      (wr_en),
    .wr_id      (wr_id),
    .dev_id     (dev_id),
    .col_lvl    (col_lvl)
);

// File: tb/lcd_col_scan_tb.sv
module lcd_col_scan_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 160;
    localparam int NL  = 240;
    localparam int NG  = NC / 4;
    localparam logic [1:0] MY_ID = 2'd2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           frame_sync = 1'b0;
    logic           line_clk = 1'b0;
    logic           ac_sel = 1'b0;
    logic           blank_n = 1'b1;
    logic           mirror = 1'b0;
    logic [1:0]     dev_id = MY_ID;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_id = '0;
    logic [7:0]     wr_row = '0;
    logic [5:0]     wr_grp = '0;
    logic [7:0]     wr_data = '0;
    logic [NC*3-1:0] col_lvl;

    lcd_col_scan u_dut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .line_clk(line_clk),
        .ac_sel(ac_sel), .blank_n(blank_n), .mirror(mirror), .dev_id(dev_id),
        .wr_en(wr_en), .wr_id(wr_id), .wr_row(wr_row), .wr_grp(wr_grp),
        .wr_data(wr_data), .col_lvl(col_lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [NC*3-1:0] v;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    int   gen_of[NL];
    int   mline = 0;
    int   cur_row = 0;

    function automatic logic [1:0] pix(int r, int c, int g);
        return 2'(r * 5 + c * 3 + (c >> 2) + g * 7);
    endfunction

    function automatic logic [NC*3-1:0] exp_vec(int r, int g, bit ac, bit bl, bit mir);
        logic [NC*3-1:0] v;
        for (int i = 0; i < NC; i++) begin
            logic [1:0] p;
            p = pix(r, mir ? NC - 1 - i : i, g);
            if (!bl)      v[3*i +: 3] = 3'b111;
            else if (ac)  v[3*i +: 3] = {1'b1, ~p};
            else          v[3*i +: 3] = {1'b0, p};
        end
        return v;
    endfunction

    function automatic void push(logic [NC*3-1:0] v, string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        q.push_back(e);
    endfunction

    function automatic void push_row(string tag);
        push(exp_vec(cur_row, gen_of[cur_row], ac_sel, blank_n, mirror), tag);
    endfunction

    // monitor: compares on falling edges, away from the registered update
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (col_lvl !== e.v) begin
                failures++;
                $display("FAIL %s: col_lvl=%h expected=%h", e.tag, col_lvl, e.v);
            end
        end
    end

    task automatic do_write(logic [1:0] id, int row, int grp, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_id = id; wr_row = 8'(row); wr_grp = 6'(grp); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_row(int row, int g, logic [1:0] id);
        for (int grp = 0; grp < NG; grp++) begin
            logic [7:0] d;
            for (int k = 0; k < 4; k++)
                d[2*k +: 2] = pix(row, 4 * grp + k, g);
            do_write(id, row, grp, d);
        end
        if (id == MY_ID) gen_of[row] = g;
    endtask

    task automatic line_pulse(bit chk, string tag);
        @(negedge clk);
        line_clk = 1'b1;
        @(negedge clk);
        line_clk = 1'b0;
        if (frame_sync) begin
            cur_row = 0;
            mline = 0;
        end else begin
            cur_row = mline;
            mline = (mline == NL - 1) ? 0 : mline + 1;
        end
        repeat (2) @(posedge clk);
        #1;
        if (chk) push_row(tag);
    endtask

    task automatic set_ctrl(bit ac, bit bl, bit mir, string tag);
        @(negedge clk);
        ac_sel = ac; blank_n = bl; mirror = mir;
        @(posedge clk);
        #1;
        push_row(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) gen_of[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        push('0, "R1 reset outputs zero");
        @(negedge clk);
        rst = 1'b0;

        for (int r = 0; r < 6; r++) write_row(r, 0, MY_ID);
        write_row(NL - 1, 0, MY_ID);

        line_pulse(1, "R1 first line after reset is row 0");
        line_pulse(1, "R2 R10 second line row 1");
        line_pulse(1, "R2 third line row 2");

        set_ctrl(1, 1, 0, "R5 negative polarity");
        set_ctrl(0, 1, 0, "R5 positive polarity");

        set_ctrl(0, 0, 0, "R6 blank forces select-high");
        write_row(3, 1, MY_ID);
        write_row(4, 1, 2'd1);
        push(exp_vec(0, 0, 0, 0, 0), "R6 blank held during writes");
        set_ctrl(0, 1, 0, "R6 row 2 restored after blank");

        line_pulse(1, "R7 row 3 written during blank");
        line_pulse(1, "R9 row 4 unchanged by foreign id");

        set_ctrl(1, 1, 1, "R8 mirrored order");
        line_pulse(1, "R8 mirrored row 5");
        set_ctrl(0, 1, 0, "R8 mirror off");

        @(negedge clk);
        frame_sync = 1'b1;
        line_pulse(1, "R4 frame start latches row 0");
        @(negedge clk);
        frame_sync = 1'b0;
        line_pulse(1, "R4 line after frame start is row 0");
        line_pulse(1, "R2 counting resumes row 1");

        @(negedge clk);
        frame_sync = 1'b1;
        line_pulse(0, "");
        @(negedge clk);
        frame_sync = 1'b0;
        for (int k = 0; k < NL; k++)
            line_pulse(k == NL - 1, "R3 last line row 239");
        line_pulse(1, "R3 wrap to row 0");

        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule